// File: doc/BRIEF.md
# Pulse-Per-Second Edge Timestamp Unit

This unit timestamps the rising edge of an external pulse-per-second signal with tick resolution and no polling error. The system clock is divided by four to produce a counting tick. Two counters advance on that tick. The timebase counter runs freely and wraps. The elapsed counter is cleared on each synchronized rising edge of the pulse and then counts up from zero. With a 33.333 MHz clock the tick resolution is roughly 120 ns.

Software polls the unit by writing to the poll address. That single write captures four values in the same clock cycle: the synchronized pulse level, the timebase, the elapsed count and the overflow flag. The corrected timestamp is the captured timebase minus the captured elapsed count, modulo 2^W. This equals the timebase at the moment of the edge, however late the poll comes.

When a poll sees the level go from low to high, the unit does two things: it pulses a valid flag and drives an echo output high. When a poll sees the level fall, it drives the echo output low. Software can also set, clear or invert the echo output through a register.

Top module: `pps_stamp_unit`

## Requirements
- R1: A tick occurs once every four clock cycles. After e rising clock edges since reset release, the timebase (read address 1) equals floor(e/4) modulo 2^W.
- R2: Suppose the pulse input is first sampled high at clock edge n. The synchronized level (read address 0, bit 0) becomes 1 after edge n+2, and the elapsed counter is cleared at that same edge.
- R3: After the clear, the elapsed counter (read address 2) counts ticks. It saturates at 2^W-1 instead of wrapping.
- R4: The overflow flag (read address 0, bit 1) is sticky. It sets on a tick that arrives while the elapsed counter is at 2^W-1, and it is cleared by the next synchronized rising edge.
- R5: A write to address 0 is a poll. In that one clock edge it captures the level, overflow, timebase and elapsed count into snapshot registers. The flags go to read address 4 (bit 0 level, bit 1 overflow), the timebase to address 5 and the elapsed count to address 6. The snapshot holds until the next poll.
- R6: The corrected stamp (read address 7 and output stamp_value) equals snapshot timebase minus snapshot elapsed, modulo 2^W. For an edge first sampled at edge n, it equals floor((n+2)/4) modulo 2^W, whatever the poll delay.
- R7: stamp_valid is high for exactly the one cycle after a poll edge. It is raised only if the captured level is 1 and the previous poll captured 0. An unchanged level or a falling level raises no valid.
- R8: An accepted rising poll sets the echo state, and a poll that captures a falling level clears it. A write to address 3 also acts on it: bit 0 sets the state, bit 1 clears it (clear wins), and bit 2 stores the invert control. echo_out is the state XOR invert. Address 3 reads back bit 0 = state and bit 2 = invert.
- R9: stamp_stale equals the captured overflow flag of the latest poll.
- R10: After reset, the timebase, elapsed count, all flags, the snapshots, stamp_valid and echo_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse-per-second input |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data, combinational on reg_addr |
| echo_out | output | 1 | Echo of the accepted pulse, optionally inverted |
| stamp_valid | output | 1 | One-cycle flag for a new timestamp |
| stamp_value | output | W | Corrected timestamp |
| stamp_stale | output | 1 | Timestamp taken after the elapsed counter saturated |

## Verification
The bench keeps its own count of clock edges since reset release. From that count it derives the expected timebase, the edge-to-clear point at n+2 and the expected elapsed count, and it compares them at falling edges, where combinational reads are stable. A poll written at edge m produces its snapshots, stamp, valid flag and echo change right after edge m. The bench samples these at the next falling edge, then checks one cycle later that the valid flag has dropped. Because the bench uses a narrow counter width, saturation and timebase wrap both fall inside the run.

// File: rtl/pps_pkg.sv
// Package for the pulse-per-second timestamp unit.
// Holds the register address map shared by the top module and the bench.
package pps_pkg;
    typedef enum logic [2:0] {
        ADDR_POLL  = 3'd0, // write: poll; read: live {overflow, level}
        ADDR_TB    = 3'd1, // read: live timebase
        ADDR_EL    = 3'd2, // read: live elapsed count
        ADDR_ECHO  = 3'd3, // write/read: echo control
        ADDR_SFLG  = 3'd4, // read: snapshot {overflow, level}
        ADDR_STB   = 3'd5, // read: snapshot timebase
        ADDR_SEL   = 3'd6, // read: snapshot elapsed
        ADDR_STAMP = 3'd7  // read: corrected stamp
    } pps_addr_e;

    localparam int unsigned ECHO_SET_BIT = 0;
    localparam int unsigned ECHO_CLR_BIT = 1;
    localparam int unsigned ECHO_INV_BIT = 2;
endpackage

// File: rtl/pps_tick_div.sv
// Tick divider: pulses tick for one cycle out of every DIV clock cycles.
// Assumes DIV >= 2. The phase counter starts at zero on reset, so the
// first tick follows the DIV-th edge after reset release.
module pps_tick_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Advance the phase and wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/pps_sync_edge.sv
// Input synchronizer with a rising-edge detector.
// Assumes pulse_in is asynchronous. STAGES flops remove metastability.
// One more register (level_q) holds the level that the poll logic sees.
// rise fires in the cycle before level_q goes high, so the elapsed counter
// clears on the same edge that level_q rises. This keeps the edge latency
// constant and the stamp arithmetic exact.
module pps_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic level_q,
    output logic rise
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pulse_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // One further synchronizer stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    // Hold the level aligned with the elapsed-counter clear.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~level_q;
endmodule

// File: rtl/pps_counters.sv
// Timebase and elapsed counters, both advancing on the shared tick.
// The timebase wraps modulo 2^W. The elapsed counter clears on rise, then
// counts and saturates at all-ones. A sticky overflow flag records a tick
// lost to saturation. Before the first edge the elapsed counter stays idle.
module pps_counters #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rise,
    output logic [W-1:0] tb,
    output logic [W-1:0] el,
    output logic         ovf
);
    localparam logic [W-1:0] SAT = '1;

    logic running;

    // Free-running timebase.
    always_ff @(posedge clk) begin
        if (!rst_n)    tb <= '0;
        else if (tick) tb <= tb + 1'b1;
    end

    // Elapsed count since the last edge, saturating, with sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            el      <= '0;
            ovf     <= 1'b0;
            running <= 1'b0;
        end else if (rise) begin
            el      <= '0;
            ovf     <= 1'b0;
            running <= 1'b1;
        end else if (running && tick) begin
            if (el == SAT) ovf <= 1'b1;
            else           el  <= el + 1'b1;
        end
    end
endmodule

// File: rtl/pps_poll_ctrl.sv
// Poll capture, stamp generation and echo control.
// A poll copies level, overflow, timebase and elapsed count on one edge.
// Nothing else can write these snapshots, so the capture is atomic.
// Assumes the counters and level_q are registered, so the poll sees one
// consistent pre-edge state. The level is judged against the previous
// poll's level: a rise is accepted (valid pulse, echo high) and a fall
// drops the echo.
module pps_poll_ctrl #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         poll,
    input  logic         level,
    input  logic         ovf,
    input  logic [W-1:0] tb,
    input  logic [W-1:0] el,
    input  logic         echo_wr,
    input  logic         echo_set,
    input  logic         echo_clr,
    input  logic         echo_inv_in,
    output logic         snap_lvl,
    output logic         snap_ovf,
    output logic [W-1:0] snap_tb,
    output logic [W-1:0] snap_el,
    output logic [W-1:0] stamp,
    output logic         stamp_valid,
    output logic         echo_state,
    output logic         echo_inv
);
    logic prev_lvl;
    logic accept;
    logic drop;

    assign accept = poll & level & ~prev_lvl;
    assign drop   = poll & ~level & prev_lvl;

    // Capture all poll values on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_lvl <= 1'b0;
            snap_ovf <= 1'b0;
            snap_tb  <= '0;
            snap_el  <= '0;
            prev_lvl <= 1'b0;
        end else if (poll) begin
            snap_lvl <= level;
            snap_ovf <= ovf;
            snap_tb  <= tb;
            snap_el  <= el;
            prev_lvl <= level;
        end
    end

    // One-cycle valid for an accepted rising level.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp_valid <= 1'b0;
        else        stamp_valid <= accept;
    end

    // Echo state: poll events and register writes (clear beats set).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_state <= 1'b0;
            echo_inv   <= 1'b0;
        end else if (echo_wr) begin
            echo_inv <= echo_inv_in;
            if (echo_clr)      echo_state <= 1'b0;
            else if (echo_set) echo_state <= 1'b1;
        end else if (accept) begin
            echo_state <= 1'b1;
        end else if (drop) begin
            echo_state <= 1'b0;
        end
    end

    assign stamp = snap_tb - snap_el;
endmodule

// File: rtl/pps_stamp_unit.sv
// Pulse-per-second edge timestamp unit, top level.
// Chains the divider, synchronizer, counters and poll logic. It decodes a
// simple register port: writes take effect on the clock edge, and reads
// are combinational on reg_addr. Assumes W >= 3 so the echo control bits
// fit in a register word.
module pps_stamp_unit
    import pps_pkg::*;
#(
    parameter int unsigned W         = 16,
    parameter int unsigned DIV       = 4,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pulse_in,
    input  logic [2:0]   reg_addr,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         echo_out,
    output logic         stamp_valid,
    output logic [W-1:0] stamp_value,
    output logic         stamp_stale
);
    logic         tick;
    logic         level;
    logic         rise;
    logic [W-1:0] tb_val;
    logic [W-1:0] el_val;
    logic         ovf;
    logic         poll;
    logic         echo_wr;
    logic         snap_lvl;
    logic         snap_ovf;
    logic [W-1:0] snap_tb;
    logic [W-1:0] snap_el;
    logic [W-1:0] stamp;
    logic         echo_state;
    logic         echo_inv;

    assign poll    = reg_wr && (reg_addr == ADDR_POLL);
    assign echo_wr = reg_wr && (reg_addr == ADDR_ECHO);

    pps_tick_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pps_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (pulse_in),
        .level_q  (level),
        .rise     (rise)
    );

    pps_counters #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rise  (rise),
        .tb    (tb_val),
        .el    (el_val),
        .ovf   (ovf)
    );

    pps_poll_ctrl #(.W(W)) u_poll (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll        (poll),
        .level       (level),
        .ovf         (ovf),
        .tb          (tb_val),
        .el          (el_val),
        .echo_wr     (echo_wr),
        .echo_set    (reg_wdata[ECHO_SET_BIT]),
        .echo_clr    (reg_wdata[ECHO_CLR_BIT]),
        .echo_inv_in (reg_wdata[ECHO_INV_BIT]),
        .snap_lvl    (snap_lvl),
        .snap_ovf    (snap_ovf),
        .snap_tb     (snap_tb),
        .snap_el     (snap_el),
        .stamp       (stamp),
        .stamp_valid (stamp_valid),
        .echo_state  (echo_state),
        .echo_inv    (echo_inv)
    );

    // Read multiplexer over live state, snapshots and the stamp.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_POLL:  reg_rdata[1:0] = {ovf, level};
            ADDR_TB:    reg_rdata      = tb_val;
            ADDR_EL:    reg_rdata      = el_val;
            ADDR_ECHO: begin
                reg_rdata[ECHO_SET_BIT] = echo_state;
                reg_rdata[ECHO_INV_BIT] = echo_inv;
            end
            ADDR_SFLG:  reg_rdata[1:0] = {snap_ovf, snap_lvl};
            ADDR_STB:   reg_rdata      = snap_tb;
            ADDR_SEL:   reg_rdata      = snap_el;
            default:    reg_rdata      = stamp;
        endcase
    end

    assign echo_out    = echo_state ^ echo_inv;
    assign stamp_value = stamp;
    assign stamp_stale = snap_ovf;
endmodule

// File: rtl/pps_stamp_checker.sv
// Property checker for pps_stamp_unit, attached by bind.
// It relates signals driven by the separate submodules over time.
module pps_stamp_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         rise,
    input logic [W-1:0] tb_val,
    input logic [W-1:0] el_val,
    input logic         ovf,
    input logic         poll,
    input logic         stamp_valid,
    input logic         echo_state,
    input logic [W-1:0] snap_tb
);
    localparam logic [W-1:0] SAT = '1;

    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick ##1 !tick ##1 !tick ##1 tick);

    assert_tb_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> tb_val == $past(tb_val) + 1'b1);

    assert_tb_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tb_val));

    assert_clear_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (el_val == '0) && !ovf);

    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (el_val == SAT) && !rise |=> el_val == SAT);

    assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !rise |=> ovf);

    assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(el_val) == SAT);

    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !poll |=> $stable(snap_tb));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid |=> !stamp_valid);

    assert_valid_after_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stamp_valid) |-> $past(poll));

    assert_echo_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid |-> echo_state);
endmodule

bind pps_stamp_unit pps_stamp_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rise        (rise),
    .tb_val      (tb_val),
    .el_val      (el_val),
    .ovf         (ovf),
    .poll        (poll),
    .stamp_valid (stamp_valid),
    .echo_state  (echo_state),
    .snap_tb     (snap_tb)
);

// File: tb/pps_stamp_unit_bench.sv
// Directed bench for pps_stamp_unit. The counter width is narrowed so that
// saturation and wrap both occur within the run.
module pps_stamp_unit_bench;
    import pps_pkg::*;

    localparam int unsigned W    = 10;
    localparam int          MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pulse_in = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic         reg_wr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         echo_out;
    logic         stamp_valid;
    logic [W-1:0] stamp_value;
    logic         stamp_stale;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int wd     = 0;
    int edge_n = 0;

    pps_stamp_unit #(.W(W)) u_pps_stamp_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_in    (pulse_in),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .echo_out    (echo_out),
        .stamp_valid (stamp_valid),
        .stamp_value (stamp_value),
        .stamp_stale (stamp_stale)
    );

    always #2 clk = ~clk;

    // Edge count since reset release, used as the reference time.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = W'(d);
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // Poll and check the one-cycle valid window; returns the pre-poll cycle.
    task automatic poll(input int exp_valid, input string tag, output int pc);
        @(negedge clk);
        reg_addr = ADDR_POLL;
        reg_wr   = 1'b1;
        pc       = cyc;
        @(negedge clk);
        chk({tag, " valid"}, int'(stamp_valid), exp_valid);
        reg_wr = 1'b0;
        @(negedge clk);
        chk({tag, " valid drop"}, int'(stamp_valid), 0);
    endtask

    task automatic t_reset;
        int v;
        rd(ADDR_TB, v);    chk("R10 tb reset", v, (cyc / 4) & MASK);
        rd(ADDR_EL, v);    chk("R10 el reset", v, 0);
        rd(ADDR_POLL, v);  chk("R10 flags reset", v, 0);
        rd(ADDR_STAMP, v); chk("R10 stamp reset", v, 0);
        chk("R10 echo reset", int'(echo_out), 0);
        chk("R10 valid reset", int'(stamp_valid), 0);
    endtask

    task automatic t_timebase;
        int v;
        for (int i = 0; i < 6; i++) begin
            rd(ADDR_TB, v);
            chk("R1 timebase", v, (cyc / 4) & MASK);
            repeat (i + 1) @(negedge clk);
        end
    endtask

    task automatic t_rise;
        int v;
        int pc;
        @(negedge clk);
        pulse_in = 1'b1;
        edge_n   = cyc + 1;
        while (cyc < edge_n + 1) @(negedge clk);
        reg_addr = ADDR_POLL; #1;
        chk("R2 level before n+2", int'(reg_rdata[0]), 0);
        @(negedge clk); #1;
        chk("R2 level after n+2", int'(reg_rdata[0]), 1);
        reg_addr = ADDR_EL; #1;
        chk("R2 elapsed cleared", int'(reg_rdata), 0);
        repeat (37) @(negedge clk);
        rd(ADDR_EL, v);
        chk("R3 elapsed counts", v, cyc / 4 - (edge_n + 2) / 4);
        poll(1, "R7 rise poll", pc);
        chk("R6 stamp", int'(stamp_value), ((edge_n + 2) / 4) & MASK);
        chk("R8 echo high", int'(echo_out), 1);
        rd(ADDR_STB, v);  chk("R5 snap tb", v, (pc / 4) & MASK);
        rd(ADDR_SEL, v);  chk("R5 snap el", v, pc / 4 - (edge_n + 2) / 4);
        rd(ADDR_SFLG, v); chk("R5 snap flags", v, 1);
        chk("R9 not stale", int'(stamp_stale), 0);
    endtask

    task automatic t_repoll;
        int v;
        int pc;
        repeat (213) @(negedge clk);
        poll(0, "R7 unchanged poll", pc);
        rd(ADDR_STAMP, v);
        chk("R6 stamp after late poll", v, ((edge_n + 2) / 4) & MASK);
        rd(ADDR_STB, v);
        chk("R5 snap tb late", v, (pc / 4) & MASK);
    endtask

    task automatic t_fall;
        int pc;
        @(negedge clk);
        pulse_in = 1'b0;
        repeat (5) @(negedge clk);
        poll(0, "R7 fall poll", pc);
        chk("R8 echo low on fall", int'(echo_out), 0);
    endtask

    task automatic t_echo_regs;
        int v;
        wr(ADDR_ECHO, 1); chk("R8 echo set", int'(echo_out), 1);
        rd(ADDR_ECHO, v); chk("R8 echo readback", v, 1);
        wr(ADDR_ECHO, 3); chk("R8 clear wins", int'(echo_out), 0);
        wr(ADDR_ECHO, 4); chk("R8 inverted idle", int'(echo_out), 1);
        rd(ADDR_ECHO, v); chk("R8 invert readback", v, 4);
        wr(ADDR_ECHO, 0); chk("R8 invert off", int'(echo_out), 0);
    endtask

    task automatic t_saturate;
        int v;
        int pc;
        @(negedge clk);
        pulse_in = 1'b1;
        edge_n   = cyc + 1;
        while (cyc < edge_n + 2 + 4 * (MASK + 3)) @(negedge clk);
        rd(ADDR_EL, v);   chk("R3 elapsed saturated", v, MASK);
        rd(ADDR_POLL, v); chk("R4 overflow set", v, 3);
        poll(1, "R7 stale poll", pc);
        chk("R9 stale flag", int'(stamp_stale), 1);
        chk("R6 stamp saturated", int'(stamp_value), ((pc / 4) - MASK) & MASK);
        rd(ADDR_TB, v);   chk("R1 timebase after wrap", v, (cyc / 4) & MASK);
        @(negedge clk); pulse_in = 1'b0;
        repeat (6) @(negedge clk);
        pulse_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(ADDR_POLL, v); chk("R4 overflow cleared by edge", v, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset;
        t_timebase;
        t_rise;
        t_repoll;
        t_fall;
        t_echo_regs;
        t_saturate;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule